// File: doc/BRIEF.md
# Triple-Issue Dispatch Slot Allocator

This block sits between decode and the execution pipes of a three-wide core. Each cycle it receives up to three decoded instructions in program order. Each instruction has a valid bit and a 4-bit class tag. The block decides which of them issue and which execution unit each one gets. A granted instruction books every resource it needs in a reservation table that reaches forward in time. Single-cycle operations book one cycle. A call blocks the whole machine for two cycles, and a double-precision FP divide holds the first FP pipe for 28 cycles. Later arrivals are checked against all of these bookings. Operand hazards are not considered.

The bookable resources are:
- two integer pipes, each with ALU, shift and saturate sub-stages;
- two FP/SIMD pipes;
- one branch pipe;
- one multiply/divide pipe;
- two load/store pipes;
- a load stage and a store stage;
- the three issue slots themselves.

Issue is strictly in order. An instruction that cannot obtain its complete reservation is held back, and so is every instruction behind it. The decision for the inputs presented in one cycle appears on the registered outputs after the next rising clock edge.

Top module: `tri_issue_alloc`

## Requirements
- R1: Lane 0 is the oldest instruction and lane 2 the youngest. A granted lane reports the issue slots it took on `gnt_slots[3i+2:3i]`, where bit n stands for slot n+1. Slots are handed out lowest free first, so slot 2 is never used while slot 1 is free. A lane that finds no free slot is refused.
- R2: A lane is granted only if it is valid and every older lane in the same cycle was granted. An invalid lane or a refused lane blocks all younger lanes.
- R3: Where a unit exists as a pair, the first unit is taken when it is free and the second only otherwise. Unit codes on `gnt_unit[4i+3:4i]` are: 0 int pipe 1, 1 int pipe 2, 2 FP pipe 1, 3 FP pipe 2, 4 branch, 5 multiply/divide, 6 load/store pipe 1, 7 load/store pipe 2, 15 all units. A lane that is not granted reports unit 0 and no slots.
- R4: Class 0 (simple ALU) and class 1 (plain shift) take one slot. In the following cycle they book one integer pipe together with that pipe's ALU stage (class 0) or its shift stage (class 1).
- R5: Class 2 (ALU with shifted operand) books the chosen integer pipe one cycle after issue. Two cycles after issue it books the same pipe plus its shift stage, and three cycles after issue it books that pipe's ALU stage.
- R6: Class 4 (call) needs at least two free slots and takes all free slots. One cycle after issue it books every main unit: both int pipes, both FP pipes, branch, multiply/divide and both load/store pipes. Two cycles after issue it books every ALU, shift and saturate stage plus the load and store stages. It reports unit 15.
- R7: Class 10 (single-precision FP divide/sqrt) holds FP pipe 1 for the 13 cycles after issue. Class 11 (double-precision) holds it for 28 cycles. Class 9 (FP ALU) needs an FP pipe only in its issue cycle.
- R8: Class 6 (widening multiply) holds the multiply/divide pipe for the 2 cycles after issue. Class 5 (multiply) holds it for the 1 cycle after issue. Class 3 (branch) books the branch pipe for the cycle after issue.
- R9: Class 12 (double-precision FP load/store) books the branch pipe in its issue cycle. It also books the lowest free issue slot of the following cycle and is refused if that cycle has none free.
- R10: Class 7 (load) and class 8 (store) book a load/store pipe one cycle after issue. Two cycles after issue, a load books the load stage and a store books the store stage.
- R11: Synchronous active-high reset clears the reservation table and all outputs. The outputs are registered, so a decision shows one clock after its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 3 | Valid bit per lane, lane 0 oldest |
| in_cls | input | 12 | Class tag per lane, 4 bits each, lane i at [4i+3:4i] |
| gnt | output | 3 | Registered grant per lane |
| gnt_unit | output | 12 | Registered unit code per lane |
| gnt_slots | output | 9 | Registered issue-slot mask per lane |

## Verification
The hardest states to reach are those where a booking made many cycles earlier decides a grant now. Examples are the final cycle of a 28-cycle divide hold, and an issue slot already consumed by a double-precision FP transfer from the previous cycle. The stimulus reaches them with a continuous stream of cycles. A divide is issued, idle cycles are counted out exactly, and FP ALU probes are placed on the last held cycle and on the first free one. In the same way, calls and ALU ops are placed one and two cycles after a call so that each layer of its booking is observed through refusals.

// File: rtl/tia_pkg.sv
package tia_pkg;
  localparam int LANES  = 3;
  localparam int ISSUE  = 3;
  localparam int CLS_W  = 4;
  localparam int UID_W  = 4;

  // resource bit positions in one reservation row
  localparam int U_INT1 = 0;
  localparam int U_FP1  = 2;
  localparam int U_BR   = 4;
  localparam int U_MD   = 5;
  localparam int U_LS1  = 6;
  localparam int N_MAIN = 8;
  localparam int U_ALU1 = 8;
  localparam int U_SHF1 = 10;
  localparam int U_LD   = 14;
  localparam int U_ST   = 15;
  localparam int U_IS1  = 16;
  localparam int NU     = U_IS1 + ISSUE;

  localparam logic [UID_W-1:0] UID_ALL  = 4'hF;
  localparam logic [UID_W-1:0] UID_NONE = 4'hE;

  typedef enum logic [CLS_W-1:0] {
    K_ALU   = 4'd0,
    K_SHIFT = 4'd1,
    K_ALUSH = 4'd2,
    K_BRAN  = 4'd3,
    K_CALL  = 4'd4,
    K_MUL   = 4'd5,
    K_MULL  = 4'd6,
    K_LOAD  = 4'd7,
    K_STORE = 4'd8,
    K_FPALU = 4'd9,
    K_FDIVS = 4'd10,
    K_FDIVD = 4'd11,
    K_FLSD  = 4'd12
  } op_cls_e;
endpackage

// File: rtl/tia_resv_gen.sv
module tia_resv_gen import tia_pkg::*; #(
  parameter int DEPTH    = 32,
  parameter int FDS_HOLD = 13,
  parameter int FDD_HOLD = 28
) (
  input  op_cls_e                     cls,
  input  logic                        alt,
  output logic [DEPTH-1:0][NU-1:0]    need,
  output logic [UID_W-1:0]            uid
);
  always_comb begin
    int p;
    p    = alt ? 1 : 0;
    need = '0;
    uid  = UID_NONE;
    case (cls)
      K_ALU: begin
        need[1][U_INT1+p] = 1'b1;
        need[1][U_ALU1+p] = 1'b1;
        uid = UID_W'(U_INT1 + p);
      end
      K_SHIFT: begin
        need[1][U_INT1+p] = 1'b1;
        need[1][U_SHF1+p] = 1'b1;
        uid = UID_W'(U_INT1 + p);
      end
      K_ALUSH: begin
        need[1][U_INT1+p] = 1'b1;
        need[2][U_INT1+p] = 1'b1;
        need[2][U_SHF1+p] = 1'b1;
        need[3][U_ALU1+p] = 1'b1;
        uid = UID_W'(U_INT1 + p);
      end
      K_BRAN: begin
        need[1][U_BR] = 1'b1;
        uid = UID_W'(U_BR);
      end
      K_CALL: begin
        for (int u = 0; u < N_MAIN; u++) need[1][u] = 1'b1;
        for (int u = N_MAIN; u <= U_ST; u++) need[2][u] = 1'b1;
        uid = UID_ALL;
      end
      K_MUL: begin
        need[1][U_MD] = 1'b1;
        uid = UID_W'(U_MD);
      end
      K_MULL: begin
        need[1][U_MD] = 1'b1;
        need[2][U_MD] = 1'b1;
        uid = UID_W'(U_MD);
      end
      K_LOAD: begin
        need[1][U_LS1+p] = 1'b1;
        need[2][U_LD]    = 1'b1;
        uid = UID_W'(U_LS1 + p);
      end
      K_STORE: begin
        need[1][U_LS1+p] = 1'b1;
        need[2][U_ST]    = 1'b1;
        uid = UID_W'(U_LS1 + p);
      end
      K_FPALU: begin
        need[0][U_FP1+p] = 1'b1;
        uid = UID_W'(U_FP1 + p);
      end
      K_FDIVS: begin
        for (int k = 1; k < DEPTH; k++)
          if (k <= FDS_HOLD) need[k][U_FP1] = 1'b1;
        uid = UID_W'(U_FP1);
      end
      K_FDIVD: begin
        for (int k = 1; k < DEPTH; k++)
          if (k <= FDD_HOLD) need[k][U_FP1] = 1'b1;
        uid = UID_W'(U_FP1);
      end
      K_FLSD: begin
        need[0][U_BR] = 1'b1;
        uid = UID_W'(U_BR);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tia_lane.sv
module tia_lane import tia_pkg::*; #(
  parameter int DEPTH    = 32,
  parameter int FDS_HOLD = 13,
  parameter int FDD_HOLD = 28
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vld,
  input  logic                     en_in,
  input  op_cls_e                  cls,
  input  logic [DEPTH-1:0][NU-1:0] tbl_in,
  output logic [DEPTH-1:0][NU-1:0] tbl_out,
  output logic                     grant,
  output logic [UID_W-1:0]         uid_o,
  output logic [ISSUE-1:0]         slot_o
);
  logic [DEPTH-1:0][NU-1:0] need_a, need_b, need_s;
  logic [UID_W-1:0]         uid_a, uid_b, uid_s;
  logic [ISSUE-1:0]         free_now, free_nxt, pick_now, pick_nxt;
  logic                     multi, wants_nxt, fit_a, fit_b, slot_ok, nxt_ok;

  tia_resv_gen #(.DEPTH(DEPTH), .FDS_HOLD(FDS_HOLD), .FDD_HOLD(FDD_HOLD)) u_pri (
    .cls(cls), .alt(1'b0), .need(need_a), .uid(uid_a));
  tia_resv_gen #(.DEPTH(DEPTH), .FDS_HOLD(FDS_HOLD), .FDD_HOLD(FDD_HOLD)) u_alt (
    .cls(cls), .alt(1'b1), .need(need_b), .uid(uid_b));

  assign multi     = (cls == K_CALL);
  assign wants_nxt = (cls == K_FLSD);
  assign free_now  = ~tbl_in[0][U_IS1 +: ISSUE];
  assign free_nxt  = ~tbl_in[1][U_IS1 +: ISSUE];
  assign pick_now  = multi ? free_now : (free_now & (~free_now + ISSUE'(1)));
  assign pick_nxt  = free_nxt & (~free_nxt + ISSUE'(1));

  assign fit_a   = ~|(need_a & tbl_in);
  assign fit_b   = ~|(need_b & tbl_in);
  assign need_s  = fit_a ? need_a : need_b;
  assign uid_s   = fit_a ? uid_a : uid_b;
  assign slot_ok = multi ? ($countones(free_now) >= 2) : (|free_now);
  assign nxt_ok  = ~wants_nxt | (|free_nxt);
  assign grant   = vld & en_in & (fit_a | fit_b) & slot_ok & nxt_ok;
  assign uid_o   = grant ? uid_s : '0;
  assign slot_o  = grant ? pick_now : '0;

  always_comb begin
    tbl_out = tbl_in;
    if (grant) begin
      tbl_out = tbl_in | need_s;
      tbl_out[0][U_IS1 +: ISSUE] = tbl_in[0][U_IS1 +: ISSUE] | pick_now;
      if (wants_nxt)
        tbl_out[1][U_IS1 +: ISSUE] = tbl_in[1][U_IS1 +: ISSUE] | pick_nxt;
    end
  end

  // R1
  slot_free_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> ((slot_o & tbl_in[0][U_IS1 +: ISSUE]) == '0));

  // R2
  blocked_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (!vld || !en_in) |-> (!grant && (tbl_out == tbl_in)));
endmodule

// File: rtl/tia_table.sv
module tia_table import tia_pkg::*; #(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DEPTH-2:0][NU-1:0] adv,
  output logic [DEPTH-1:0][NU-1:0] busy
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_row
    if (k < DEPTH-1) begin : g_mid
      always_ff @(posedge clk) begin
        if (rst) busy[k] <= '0;
        else     busy[k] <= adv[k];
      end
    end else begin : g_top
      always_ff @(posedge clk) busy[k] <= '0;
    end
  end
endmodule

// File: rtl/tri_issue_alloc.sv
module tri_issue_alloc import tia_pkg::*; #(
  parameter int DEPTH    = 32,
  parameter int FDS_HOLD = 13,
  parameter int FDD_HOLD = 28
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANES-1:0]         in_vld,
  input  logic [LANES*CLS_W-1:0]   in_cls,
  output logic [LANES-1:0]         gnt,
  output logic [LANES*UID_W-1:0]   gnt_unit,
  output logic [LANES*ISSUE-1:0]   gnt_slots
);
  localparam int ADV_ROWS = DEPTH - 1;

  logic [DEPTH-1:0][NU-1:0]    busy;
  logic [DEPTH-1:0][NU-1:0]    chain [LANES+1];
  logic [ADV_ROWS-1:0][NU-1:0] adv;
  logic [LANES-1:0]            en_ch, g_c;
  logic [LANES*UID_W-1:0]      u_c;
  logic [LANES*ISSUE-1:0]      s_c;

  assign chain[0] = busy;
  assign adv      = chain[LANES][DEPTH-1:1];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == 0) begin : g_first
      assign en_ch[i] = 1'b1;
    end else begin : g_rest
      assign en_ch[i] = g_c[i-1];
    end
    tia_lane #(.DEPTH(DEPTH), .FDS_HOLD(FDS_HOLD), .FDD_HOLD(FDD_HOLD)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .vld    (in_vld[i]),
      .en_in  (en_ch[i]),
      .cls    (op_cls_e'(in_cls[i*CLS_W +: CLS_W])),
      .tbl_in (chain[i]),
      .tbl_out(chain[i+1]),
      .grant  (g_c[i]),
      .uid_o  (u_c[i*UID_W +: UID_W]),
      .slot_o (s_c[i*ISSUE +: ISSUE])
    );

    // R6
    call_slots_chk: assert property (@(posedge clk) disable iff (rst)
      (gnt_unit[i*UID_W +: UID_W] == UID_ALL) |-> ($countones(gnt_slots[i*ISSUE +: ISSUE]) >= 2));
  end

  tia_table #(.DEPTH(DEPTH)) u_tbl (
    .clk (clk),
    .rst (rst),
    .adv (adv),
    .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt       <= '0;
      gnt_unit  <= '0;
      gnt_slots <= '0;
    end else begin
      gnt       <= g_c;
      gnt_unit  <= u_c;
      gnt_slots <= s_c;
    end
  end

  // R2
  order_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    !(gnt[2] && !gnt[1]) && !(gnt[1] && !gnt[0]));

  // R1
  slot_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    ((gnt_slots[2:0] & gnt_slots[5:3]) | (gnt_slots[2:0] & gnt_slots[8:6]) |
     (gnt_slots[5:3] & gnt_slots[8:6])) == '0);

  // R11
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (gnt == '0 && gnt_unit == '0 && gnt_slots == '0));
endmodule

// File: tb/tri_issue_alloc_bench.sv
`timescale 1ns/1ps
module tri_issue_alloc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  in_vld = '0;
  logic [11:0] in_cls = '0;
  logic [2:0]  gnt;
  logic [11:0] gnt_unit;
  logic [8:0]  gnt_slots;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  tri_issue_alloc u_tri_issue_alloc (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_cls(in_cls),
    .gnt(gnt), .gnt_unit(gnt_unit), .gnt_slots(gnt_slots));

  typedef struct packed {
    logic [2:0]  vld;
    logic [11:0] cls;
    logic [2:0]  eg;
    logic [11:0] eu;
    logic [8:0]  es;
  } vec_t;

  localparam int NV = 10;
  // consecutive cycles from an empty table
  localparam vec_t VEC [NV] = '{
    '{3'b111, 12'h000, 3'b011, 12'h010, 9'b000_010_001},  // R1 R3 R4
    '{3'b111, 12'h870, 3'b111, 12'h760, 9'b100_010_001},  // R10 R3
    '{3'b111, 12'h122, 3'b011, 12'h010, 9'b000_010_001},  // R5
    '{3'b111, 12'h531, 3'b000, 12'h000, 9'b000_000_000},  // R2 R5
    '{3'b110, 12'h330, 3'b000, 12'h000, 9'b000_000_000},  // R2
    '{3'b111, 12'h356, 3'b001, 12'h005, 9'b000_000_001},  // R8
    '{3'b001, 12'h005, 3'b000, 12'h000, 9'b000_000_000},  // R8
    '{3'b001, 12'h005, 3'b001, 12'h005, 9'b000_000_001},  // R8
    '{3'b111, 12'h99A, 3'b111, 12'h322, 9'b100_010_001},  // R7 R3
    '{3'b001, 12'h009, 3'b001, 12'h003, 9'b000_000_001}   // R7
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R1/R3/R4";
      1: return "R10/R3";
      2: return "R5";
      3: return "R2/R5";
      4: return "R2";
      5, 6, 7: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic compare(input logic [2:0] eg, input logic [11:0] eu,
                         input logic [8:0] es, input string tag);
    n_chk++;
    if (gnt !== eg || gnt_unit !== eu || gnt_slots !== es) begin
      n_bad++;
      $display("FAIL %s: actual gnt=%b unit=%h slots=%b expected gnt=%b unit=%h slots=%b",
               tag, gnt, gnt_unit, gnt_slots, eg, eu, es);
    end
  endtask

  task automatic step(input logic [2:0] v, input logic [11:0] c, input logic [2:0] eg,
                      input logic [11:0] eu, input logic [8:0] es, input string tag);
    in_vld = v;
    in_cls = c;
    @(negedge clk);
    in_vld = '0;
    compare(eg, eu, es, tag);
  endtask

  task automatic idle(input int n);
    in_vld = '0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(3'b000, 12'h000, 9'h000, "R11 reset");
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      step(VEC[i].vld, VEC[i].cls, VEC[i].eg, VEC[i].eu, VEC[i].es, vtag(i));

    // single-precision divide issued 13 cycles back: last held cycle, then free
    idle(11);
    step(3'b001, 12'h009, 3'b001, 12'h003, 9'b000_000_001, "R7 fdivs last held");
    step(3'b001, 12'h009, 3'b001, 12'h002, 9'b000_000_001, "R7 fdivs released");
    step(3'b001, 12'h00B, 3'b001, 12'h002, 9'b000_000_001, "R7 fdivd issue");
    step(3'b001, 12'h00A, 3'b000, 12'h000, 9'b000_000_000, "R7 fdivs during hold");
    idle(26);
    step(3'b001, 12'h009, 3'b001, 12'h003, 9'b000_000_001, "R7 fdivd last held");
    step(3'b001, 12'h009, 3'b001, 12'h002, 9'b000_000_001, "R7 fdivd released");

    // call
    step(3'b111, 12'h334, 3'b001, 12'h00F, 9'b000_000_111, "R6 R1 call takes all slots");
    step(3'b001, 12'h000, 3'b000, 12'h000, 9'b000_000_000, "R6 alu blocked by call stages");
    step(3'b001, 12'h000, 3'b001, 12'h000, 9'b000_000_001, "R6 alu after call");
    step(3'b011, 12'h049, 3'b011, 12'h0F2, 9'b000_110_001, "R6 call on two slots");
    idle(2);
    step(3'b111, 12'h499, 3'b011, 12'h032, 9'b000_010_001, "R6 call one slot refused");

    // loads, double FP transfers
    step(3'b011, 12'h077, 3'b001, 12'h006, 9'b000_000_001, "R10 load stage conflict");
    step(3'b011, 12'h0CC, 3'b001, 12'h004, 9'b000_000_001, "R9 branch unit conflict");
    step(3'b111, 12'h000, 3'b011, 12'h010, 9'b000_100_010, "R9 R1 slot held from prior cycle");

    // reset drops a long hold
    step(3'b001, 12'h00B, 3'b001, 12'h002, 9'b000_000_001, "R7 fdivd before reset");
    in_vld = '0;
    rst = 1'b1;
    @(negedge clk);
    compare(3'b000, 12'h000, 9'h000, "R11 outputs cleared");
    rst = 1'b0;
    step(3'b001, 12'h009, 3'b001, 12'h002, 9'b000_000_001, "R11 table cleared");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule